// File: doc/BRIEF.md
# Flash Write Error Status Logic

This block is the error-reporting part of a flash write controller. It watches single-cycle event strobes from the write sequencer and collects three sticky error flags. The flags sit in the top three bits of an 8-bit status byte that software can only read. A global write-error flag is set whenever any of the three is set. Software clears the global flag with a one-cycle strobe, and that strobe also clears all three flags.

The swap-error flag has two causes, and which one applies depends on the write target:

- **Plain flash program request:** the block compares the old byte with the requested byte. It raises the flag if the request would turn any 0 bit back into a 1. This check is skipped when the target is the protection bits.
- **Emulated-EEPROM page update:** a program failure during the swap phase raises the flag. A small state machine follows the page update and then asks the sequencer, with a one-cycle abort-erase pulse, to stop at the end of the swap phase. The full old sector is therefore not erased and its data is kept.

The block also decodes, for each sector, what that sector's status bit means. The meaning depends on the global error flag, the flash-busy flag, and the EEPROM-busy and suspend flags.

The swap-tracking machine has four states:

| State | Meaning |
|---|---|
| `SW_IDLE` | No EEPROM swap is being tracked. |
| `SW_WATCH` | An EEPROM swap phase is running with no failure seen. |
| `SW_FAILED` | A swap-phase program failure has been seen. |
| `SW_ABORT` | The one cycle in which the abort-erase pulse is driven. |

Its transitions are as follows:

| From | Condition | To |
|---|---|---|
| `SW_IDLE` | EEPROM swap cycle, no failure, no end | `SW_WATCH` |
| `SW_IDLE` | EEPROM swap cycle with a failure, no end | `SW_FAILED` |
| `SW_IDLE` | Swap cycle with a failure and the end strobe together | `SW_ABORT` |
| `SW_IDLE` | Swap cycle with the end strobe and no failure | stays in `SW_IDLE` |
| `SW_WATCH` | Failure without the end strobe | `SW_FAILED` |
| `SW_WATCH` | End strobe with no failure | `SW_IDLE` |
| `SW_WATCH` | End strobe with a failure in the same cycle | `SW_ABORT` |
| `SW_FAILED` | End strobe while the swap flag is still set, or a new failure arrives with it | `SW_ABORT` |
| `SW_FAILED` | End strobe after software has cleared the flag | `SW_IDLE` |
| `SW_ABORT` | Always, in the next cycle | `SW_IDLE` |

Top module: `fw_err_status`

## Requirements
- R1: After reset the status byte is 00h, the global error flag is 0 and the abort pulse is 0. Status bits 4:0 always read 0. The flag positions are: bit 7 erase error, bit 6 program error, bit 5 swap/1-over-0 error.
- R2: A cycle with `erase_fail_i` high sets status bit 7 at the next clock edge, for either target.
- R3: A cycle with `prog_fail_i` high sets status bit 6 at the next edge. The exception is an EEPROM swap-phase cycle (`tgt_eeprom_i`=1 and `phase_i`=2), which does not set bit 6. The phase encoding is 0 idle, 1 program, 2 swap, 3 erase.
- R4: A `prog_req_i` cycle with `tgt_eeprom_i`=0 and `(new_data_i & ~old_data_i) != 0` sets status bit 5. A request that turns no 0 bit into a 1 leaves the status byte unchanged.
- R5: A program request with `tgt_protect_i`=1 never sets bit 5, whatever the data.
- R6: On an EEPROM target the 1-over-0 check is not applied. A `prog_fail_i` during an EEPROM swap-phase cycle sets bit 5 instead.
- R7: The flags are sticky until `err_clr_i`. A clear strobe with no new event returns the status byte to 00h and the global flag to 0 at the next edge.
- R8: An error event in the same cycle as `err_clr_i` wins. Its flag and the global flag stay set, and the flags without an event are cleared.
- R9: `err_o` is 1 exactly when at least one of status bits 7:5 is set.
- R10: `abort_erase_o` is high for exactly one cycle. It goes high in the cycle after a `swap_end_i` that closes an EEPROM swap phase in which a program failure occurred, provided the swap flag is still set or the failure arrives with the end strobe. A swap that ends without a failure, or after the flag has been cleared, gives no pulse.
- R11: Each sector has a 2-bit code in `sec_code_o[2x+1:2x]`. The codes are 0 don't-care, 1 write error, 2 write in progress, 3 erase suspended. If the sector's bit is 0 the code is 0. Otherwise the code is 1 if `err_o` is set, else 2 if `flash_busy_i` is set, else 3 if both `eep_busy_i` and `suspend_i` are set, else 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| erase_fail_i | input | 1 | Sequencer strobe: erase failure |
| prog_fail_i | input | 1 | Sequencer strobe: program failure |
| prog_req_i | input | 1 | Program request carrying old/new data |
| old_data_i | input | DATA_W | Current content of the target byte |
| new_data_i | input | DATA_W | Requested content |
| tgt_eeprom_i | input | 1 | 1 = emulated-EEPROM target, 0 = flash |
| tgt_protect_i | input | 1 | Request targets the protection bits |
| phase_i | input | 2 | Sequencer phase: 0 idle, 1 program, 2 swap, 3 erase |
| swap_end_i | input | 1 | Strobe: the swap phase is ending |
| err_clr_i | input | 1 | Software clear of the global error flag |
| flash_busy_i | input | 1 | Flash write in progress |
| eep_busy_i | input | 1 | EEPROM operation in progress |
| suspend_i | input | 1 | Erase suspended |
| sec_bits_i | input | NSECT | Per-sector status bits |
| status_o | output | 8 | Read-only status byte |
| err_o | output | 1 | Global write-error flag |
| abort_erase_o | output | 1 | One-cycle request to skip the final erase phase |
| sec_code_o | output | 2*NSECT | Decoded meaning of each sector bit |

## Verification
On every cycle the assertions check the following:
- the reserved bits stay zero;
- the global flag agrees with the three flags;
- each event sets its flag one edge later;
- a clean clear empties the byte;
- the abort pulse lasts one cycle and always follows an end-of-swap strobe;
- a sector whose bit is set reads as a write error while the global flag is set.

Only the bench's scenarios can show the rest:
- the full 1-over-0 data comparison, swept across all old bytes and their single-bit and extreme variants;
- that the protection target and an EEPROM target both suppress that comparison;
- that an event wins in the same cycle as a clear;
- that an abort pulse is missing when a swap succeeds or when its flag was cleared beforehand.

// File: rtl/fwes_pkg.sv
package fwes_pkg;
    localparam int STAT_W = 8;
    localparam int NFLAG  = 3;
    localparam int FL_ERASE = 2;
    localparam int FL_PROG  = 1;
    localparam int FL_SWAP  = 0;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_PROG  = 2'd1,
        PH_SWAP  = 2'd2,
        PH_ERASE = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        SEC_NONE = 2'd0,
        SEC_WERR = 2'd1,
        SEC_WIP  = 2'd2,
        SEC_SUSP = 2'd3
    } sec_code_e;

    typedef enum logic [1:0] {
        SW_IDLE   = 2'd0,
        SW_WATCH  = 2'd1,
        SW_FAILED = 2'd2,
        SW_ABORT  = 2'd3
    } swap_st_e;
endpackage

// File: rtl/fwes_flag_bank.sv
module fwes_flag_bank #(
    parameter int NFLAG = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set_i,
    input  logic             clr_i,
    output logic [NFLAG-1:0] flag_o,
    output logic             err_o
);
    // Each flag: a new event wins over a clear in the same cycle.
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        flag_o[i] <= 1'b0;
            else if (set_i[i]) flag_o[i] <= 1'b1;
            else if (clr_i)    flag_o[i] <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      err_o <= 1'b0;
        else if (|set_i) err_o <= 1'b1;
        else if (clr_i)  err_o <= 1'b0;
    end
endmodule

// File: rtl/fwes_swap_fsm.sv
module fwes_swap_fsm
    import fwes_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic swap_cyc_i,
    input  logic fail_now_i,
    input  logic swap_end_i,
    input  logic swap_flag_i,
    output logic abort_o
);
    swap_st_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SW_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SW_IDLE: begin
                if (swap_cyc_i) begin
                    if (swap_end_i)      state_d = fail_now_i ? SW_ABORT : SW_IDLE;
                    else if (fail_now_i) state_d = SW_FAILED;
                    else                 state_d = SW_WATCH;
                end
            end
            SW_WATCH: begin
                if (swap_end_i)      state_d = fail_now_i ? SW_ABORT : SW_IDLE;
                else if (fail_now_i) state_d = SW_FAILED;
            end
            SW_FAILED: begin
                if (swap_end_i)
                    state_d = (swap_flag_i || fail_now_i) ? SW_ABORT : SW_IDLE;
            end
            SW_ABORT: state_d = SW_IDLE;
        endcase
    end

    always_comb begin
        abort_o = (state_q == SW_ABORT);
    end
endmodule

// File: rtl/fwes_sector_decode.sv
module fwes_sector_decode
    import fwes_pkg::*;
#(
    parameter int NSECT = 4
) (
    input  logic [NSECT-1:0]   sec_bits_i,
    input  logic               err_i,
    input  logic               flash_busy_i,
    input  logic               eep_busy_i,
    input  logic               suspend_i,
    output logic [2*NSECT-1:0] sec_code_o
);
    sec_code_e meaning;

    always_comb begin
        if (err_i)                         meaning = SEC_WERR;
        else if (flash_busy_i)             meaning = SEC_WIP;
        else if (eep_busy_i && suspend_i)  meaning = SEC_SUSP;
        else                               meaning = SEC_NONE;
    end

    for (genvar s = 0; s < NSECT; s++) begin : g_sec
        assign sec_code_o[2*s +: 2] = sec_bits_i[s] ? meaning : SEC_NONE;
    end
endmodule

// File: rtl/fw_err_status.sv
module fw_err_status
    import fwes_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NSECT  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                erase_fail_i,
    input  logic                prog_fail_i,
    input  logic                prog_req_i,
    input  logic [DATA_W-1:0]   old_data_i,
    input  logic [DATA_W-1:0]   new_data_i,
    input  logic                tgt_eeprom_i,
    input  logic                tgt_protect_i,
    input  logic [1:0]          phase_i,
    input  logic                swap_end_i,
    input  logic                err_clr_i,
    input  logic                flash_busy_i,
    input  logic                eep_busy_i,
    input  logic                suspend_i,
    input  logic [NSECT-1:0]    sec_bits_i,
    output logic [STAT_W-1:0]   status_o,
    output logic                err_o,
    output logic                abort_erase_o,
    output logic [2*NSECT-1:0]  sec_code_o
);
    localparam int RSVD_W = STAT_W - NFLAG;

    phase_e           phase;
    logic             swap_cyc;
    logic             fail_in_swap;
    logic             one_over_zero;
    logic [NFLAG-1:0] set_ev;
    logic [NFLAG-1:0] flags;

    assign phase         = phase_e'(phase_i);
    assign swap_cyc      = tgt_eeprom_i && (phase == PH_SWAP);
    assign fail_in_swap  = swap_cyc && prog_fail_i;
    assign one_over_zero = prog_req_i && !tgt_eeprom_i && !tgt_protect_i
                           && (|(new_data_i & ~old_data_i));

    always_comb begin
        set_ev           = '0;
        set_ev[FL_ERASE] = erase_fail_i;
        set_ev[FL_PROG]  = prog_fail_i && !swap_cyc;
        set_ev[FL_SWAP]  = one_over_zero || fail_in_swap;
    end

    fwes_flag_bank #(.NFLAG(NFLAG)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_ev),
        .clr_i  (err_clr_i),
        .flag_o (flags),
        .err_o  (err_o)
    );

    fwes_swap_fsm u_swap (
        .clk         (clk),
        .rst_n       (rst_n),
        .swap_cyc_i  (swap_cyc),
        .fail_now_i  (fail_in_swap),
        .swap_end_i  (swap_end_i),
        .swap_flag_i (flags[FL_SWAP]),
        .abort_o     (abort_erase_o)
    );

    fwes_sector_decode #(.NSECT(NSECT)) u_sec (
        .sec_bits_i   (sec_bits_i),
        .err_i        (err_o),
        .flash_busy_i (flash_busy_i),
        .eep_busy_i   (eep_busy_i),
        .suspend_i    (suspend_i),
        .sec_code_o   (sec_code_o)
    );

    assign status_o = {flags, {RSVD_W{1'b0}}};
endmodule

// File: rtl/fwes_chk.sv
module fwes_chk
    import fwes_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NSECT  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               erase_fail_i,
    input logic               prog_fail_i,
    input logic               prog_req_i,
    input logic [DATA_W-1:0]  old_data_i,
    input logic [DATA_W-1:0]  new_data_i,
    input logic               tgt_eeprom_i,
    input logic               tgt_protect_i,
    input logic [1:0]         phase_i,
    input logic               swap_end_i,
    input logic               err_clr_i,
    input logic [NSECT-1:0]   sec_bits_i,
    input logic [STAT_W-1:0]  status_o,
    input logic               err_o,
    input logic               abort_erase_o,
    input logic [2*NSECT-1:0] sec_code_o
);
    // R1
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[STAT_W-NFLAG-1:0] == '0);

    // R2
    erase_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_fail_i |=> status_o[7]);

    // R3
    prog_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_fail_i && !(tgt_eeprom_i && phase_i == 2'd2)) |=> status_o[6]);

    // R4
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_req_i && !tgt_eeprom_i && !tgt_protect_i
         && (new_data_i & ~old_data_i) != '0) |=> status_o[5]);

    // R6
    swap_fail_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_fail_i && tgt_eeprom_i && phase_i == 2'd2) |=> status_o[5]);

    // R7
    clean_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr_i && !erase_fail_i && !prog_fail_i && !prog_req_i)
        |=> (status_o == '0 && !err_o));

    // R7
    sticky_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[7] && !err_clr_i) |=> status_o[7]);

    // R9
    err_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o == (|status_o[7:5]));

    // R10
    abort_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_erase_o |=> !abort_erase_o);

    // R10
    abort_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(abort_erase_o) |-> $past(swap_end_i));

    // R11
    sec_werr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_bits_i[0] && err_o) |-> sec_code_o[1:0] == 2'd1);
endmodule

bind fw_err_status fwes_chk #(.DATA_W(DATA_W), .NSECT(NSECT)) u_fwes_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .erase_fail_i  (erase_fail_i),
    .prog_fail_i   (prog_fail_i),
    .prog_req_i    (prog_req_i),
    .old_data_i    (old_data_i),
    .new_data_i    (new_data_i),
    .tgt_eeprom_i  (tgt_eeprom_i),
    .tgt_protect_i (tgt_protect_i),
    .phase_i       (phase_i),
    .swap_end_i    (swap_end_i),
    .err_clr_i     (err_clr_i),
    .sec_bits_i    (sec_bits_i),
    .status_o      (status_o),
    .err_o         (err_o),
    .abort_erase_o (abort_erase_o),
    .sec_code_o    (sec_code_o)
);

// File: tb/tb_fw_err_status.sv
`timescale 1ns/1ps
module tb_fw_err_status;
    localparam int DW = 8;
    localparam int NS = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic erase_fail, prog_fail, prog_req, tgt_eep, tgt_prot, swap_end, err_clr;
    logic fbusy, ebusy, susp;
    logic [DW-1:0] old_d, new_d;
    logic [1:0] phase;
    logic [NS-1:0] sbits;
    logic [7:0] status;
    logic err, abort_e;
    logic [2*NS-1:0] scode;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fw_err_status #(.DATA_W(DW), .NSECT(NS)) dut (
        .clk(clk), .rst_n(rst_n),
        .erase_fail_i(erase_fail), .prog_fail_i(prog_fail), .prog_req_i(prog_req),
        .old_data_i(old_d), .new_data_i(new_d),
        .tgt_eeprom_i(tgt_eep), .tgt_protect_i(tgt_prot),
        .phase_i(phase), .swap_end_i(swap_end), .err_clr_i(err_clr),
        .flash_busy_i(fbusy), .eep_busy_i(ebusy), .suspend_i(susp),
        .sec_bits_i(sbits),
        .status_o(status), .err_o(err), .abort_erase_o(abort_e), .sec_code_o(scode)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic idle();
        erase_fail = 0; prog_fail = 0; prog_req = 0; tgt_eep = 0; tgt_prot = 0;
        swap_end = 0; err_clr = 0; phase = 2'd0; old_d = '0; new_d = '0;
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic clear();
        idle(); err_clr = 1; cyc(); idle();
    endtask

    function automatic logic [1:0] exp_code(input logic b, input logic e,
                                            input logic f, input logic eb, input logic s);
        if (!b) return 2'd0;
        if (e) return 2'd1;
        if (f) return 2'd2;
        if (eb && s) return 2'd3;
        return 2'd0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        idle(); fbusy = 0; ebusy = 0; susp = 0; sbits = '0;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        chk("R1 status", status, 8'h00);
        chk("R1 err", err, 0);
        chk("R1 abort", abort_e, 0);

        // R2 erase failure on both targets, R7 stickiness and clear
        for (int t = 0; t < 2; t++) begin
            erase_fail = 1; tgt_eep = t[0]; cyc(); idle();
            chk("R2 bit7", status, 8'h80);
            chk("R9 err", err, 1);
            repeat (3) cyc();
            chk("R7 sticky", status, 8'h80);
            clear(); cyc();
            chk("R7 cleared", status, 8'h00);
            chk("R7 err cleared", err, 0);
        end

        // R3 / R6 program failure over all phases and targets
        for (int t = 0; t < 2; t++) begin
            for (int p = 0; p < 4; p++) begin
                logic in_swap;
                in_swap = (t == 1) && (p == 2);
                prog_fail = 1; tgt_eep = t[0]; phase = p[1:0]; cyc(); idle();
                if (in_swap) chk("R6 swap fail sets bit5", status, 8'h20);
                else         chk("R3 prog fail sets bit6", status, 8'h40);
                chk("R9 err", err, 1);
                clear(); cyc();
                chk("R7 cleared", status, 8'h00);
                // end the swap phase after the flag was cleared: no pulse (R10)
                tgt_eep = 1; phase = 2'd2; swap_end = 1; cyc(); idle();
                chk("R10 no abort after clear", abort_e, 0);
            end
        end

        // R4 / R5 sweep of the 1-over-0 check
        for (int pr = 0; pr < 2; pr++) begin
            for (int o = 0; o < 256; o++) begin
                for (int k = 0; k < 11; k++) begin
                    logic [7:0] nv;
                    logic [7:0] ex;
                    if (k < 8)       nv = 8'(o) ^ (8'd1 << k);
                    else if (k == 8) nv = 8'(o);
                    else if (k == 9) nv = 8'hFF;
                    else             nv = 8'h00;
                    ex = ((pr == 0) && ((nv & ~8'(o)) != 0)) ? 8'h20 : 8'h00;
                    prog_req = 1; tgt_prot = pr[0]; old_d = 8'(o); new_d = nv;
                    cyc(); idle();
                    if (pr == 0) chk("R4 one-over-zero", status, ex);
                    else         chk("R5 protect skip", status, ex);
                    if (ex != 0) begin
                        clear(); cyc();
                    end
                end
            end
        end

        // R6 EEPROM target skips the data check
        prog_req = 1; tgt_eep = 1; old_d = 8'h00; new_d = 8'hFF; phase = 2'd1; cyc(); idle();
        chk("R6 eeprom no data check", status, 8'h00);

        // R8 event wins over clear
        prog_fail = 1; cyc(); idle();
        prog_req = 1; old_d = 8'h0F; new_d = 8'hF0; cyc(); idle();
        chk("R8 setup", status, 8'h60);
        err_clr = 1; erase_fail = 1; cyc(); idle();
        chk("R8 erase wins", status, 8'h80);
        chk("R8 err kept", err, 1);
        err_clr = 1; prog_fail = 1; cyc(); idle();
        chk("R8 prog wins", status, 8'h40);
        clear(); cyc();

        // R10 swap without failure
        tgt_eep = 1; phase = 2'd2; cyc(); cyc(); swap_end = 1; cyc(); idle();
        chk("R10 clean swap no abort", abort_e, 0);
        chk("R10 clean swap status", status, 8'h00);

        // R10 failure then end
        tgt_eep = 1; phase = 2'd2; cyc();
        prog_fail = 1; cyc(); prog_fail = 0; cyc();
        swap_end = 1; cyc(); idle();
        chk("R10 abort pulse", abort_e, 1);
        chk("R10 swap flag", status, 8'h20);
        cyc();
        chk("R10 pulse one cycle", abort_e, 0);
        clear(); cyc();

        // R10 failure together with end
        tgt_eep = 1; phase = 2'd2; cyc();
        prog_fail = 1; swap_end = 1; cyc(); idle();
        chk("R10 abort same cycle", abort_e, 1);
        cyc();
        chk("R10 pulse ends", abort_e, 0);
        clear(); cyc();

        // R10 flash target in swap phase: program error, no abort
        phase = 2'd2; prog_fail = 1; cyc(); prog_fail = 0; swap_end = 1; cyc(); idle();
        chk("R3 flash swap-phase fail", status, 8'h40);
        chk("R10 no abort for flash", abort_e, 0);
        clear(); cyc();

        // R11 exhaustive sector decode, global flag clear and set
        for (int e = 0; e < 2; e++) begin
            if (e == 1) begin
                erase_fail = 1; cyc(); idle();
            end
            for (int b = 0; b < 16; b++) begin
                for (int f = 0; f < 8; f++) begin
                    sbits = 4'(b); fbusy = f[2]; ebusy = f[1]; susp = f[0];
                    #1;
                    for (int s = 0; s < NS; s++)
                        chk("R11 sector code", scode[2*s +: 2],
                            exp_code(sbits[s], e[0], fbusy, ebusy, susp));
                end
            end
            sbits = '0; fbusy = 0; ebusy = 0; susp = 0;
            clear(); cyc();
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule